// File: doc/BRIEF.md
# Decode-Stage Next-Address and Branch Resolver

This block picks the address of the next instruction while a control-transfer instruction sits in the decode stage of a five-stage, in-order pipeline with 32-bit byte addresses and word-aligned instructions. It takes the already-incremented fetch address, the 16-bit signed branch displacement, the 26-bit jump field and three decode flags: equal-branch, not-equal-branch and jump. It also takes the two source operands after the forwarding multiplexers have resolved them.

A dedicated equality comparator settles the branch condition in decode rather than in the ALU stage. The block drives out the chosen next address together with a redirect strobe. That strobe steers the fetch address multiplexer and clears the fetch/decode pipeline register into a no-op, so a taken transfer discards only the single instruction fetched behind it.

The block is purely combinational. Its answer is valid in the same cycle as its inputs, and the fetch stage registers it at the next edge.

Top module: `npc_decode_resolve`

## Requirements
- R1: With is_beq, is_bne and is_jmp all 0, next_pc equals pc_inc with bits [1:0] forced to 00 and redirect_flush is 0, whatever the operands hold.
- R2: A taken branch produces next_pc = pc_inc + 4 * sign_extend(br_off), with br_off a 16-bit two's-complement word displacement.
- R3: When is_beq is 1 and is_jmp is 0, the branch is taken exactly when opnd_a equals opnd_b in all 32 bits; otherwise next_pc falls through to pc_inc.
- R4: When is_bne is 1 and is_beq and is_jmp are 0, the branch is taken exactly when opnd_a differs from opnd_b in any bit.
- R5: When is_jmp is 1, next_pc = {pc_inc[31:28], jmp_field[25:0], 2'b00}, independent of the operands.
- R6: redirect_flush is 1 in the same cycle as its inputs if and only if a jump is requested or a branch is taken; when it is 0, next_pc is the fall-through address.
- R7: Address arithmetic runs on 30-bit word addresses: bits [1:0] of next_pc are always 00, and the branch sum wraps modulo 2^30 words (for example pc_inc = 0 with br_off = 16'hFFFF gives 32'hFFFF_FFFC).
- R8: When several flags are 1 at once, is_jmp takes priority over is_beq, and is_beq takes priority over is_bne.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_inc | input | 32 | Fetch address of the branch plus 4 |
| br_off | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word-address field of a jump |
| is_beq | input | 1 | Decoded branch-if-equal |
| is_bne | input | 1 | Decoded branch-if-not-equal |
| is_jmp | input | 1 | Decoded unconditional jump |
| opnd_a | input | 32 | First forwarded source operand |
| opnd_b | input | 32 | Second forwarded source operand |
| next_pc | output | 32 | Selected next fetch address |
| redirect_flush | output | 1 | Select target and clear fetch/decode register |

## Verification
Two things can arise in the same cycle: a jump request, and a branch flag whose comparator result would also redirect. The bench provokes this by raising is_jmp together with is_beq while the operands are equal, and again with is_bne while the operands differ. In each case it expects the jump address rather than the branch target, with a single flush. It also puts a fall-through branch beside the no-flag case, so that a comparator result leaking into the idle path would show up as a spurious flush.

// File: rtl/npc_pkg.sv
// Package: shared widths and the next-address source selector.
// Assumes byte addresses with word-aligned instructions (two zero low bits).
package npc_pkg;
    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 16;
    localparam int JFLD_W  = 26;
    localparam int DATA_W  = 32;
    localparam int ALIGN_W = 2;
    localparam int WORD_W  = ADDR_W - ALIGN_W;
    localparam int REGION_W = WORD_W - JFLD_W;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } npc_src_e;
endpackage

// File: rtl/npc_target_gen.sv
// Target generator: forms branch and jump word addresses from the incremented PC.
// Assumes pc_inc is word aligned; its low bits are ignored.
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_OFF_W  = OFF_W,
    parameter int P_JFLD_W = JFLD_W
) (
    input  logic [P_ADDR_W-1:0] pc_inc,
    input  logic [P_OFF_W-1:0]  br_off,
    input  logic [P_JFLD_W-1:0] jmp_field,
    output logic [P_ADDR_W-1:0] seq_addr,
    output logic [P_ADDR_W-1:0] br_addr,
    output logic [P_ADDR_W-1:0] jmp_addr
);
    localparam int LW = P_ADDR_W - ALIGN_W;
    localparam int RW = LW - P_JFLD_W;

    logic [LW-1:0] seq_word;
    logic [LW-1:0] off_word;
    logic [LW-1:0] br_word;

    // Word-address arithmetic: sign-extend the displacement and add.
    always_comb begin
        seq_word = pc_inc[P_ADDR_W-1:ALIGN_W];
        off_word = {{(LW-P_OFF_W){br_off[P_OFF_W-1]}}, br_off};
        br_word  = seq_word + off_word;
    end

    // Re-append the alignment zeros and build the region-relative jump target.
    always_comb begin
        seq_addr = {seq_word, {ALIGN_W{1'b0}}};
        br_addr  = {br_word, {ALIGN_W{1'b0}}};
        jmp_addr = {seq_word[LW-1 -: RW], jmp_field, {ALIGN_W{1'b0}}};
    end
endmodule

// File: rtl/npc_compare.sv
// Equality comparator: reduces the two forwarded operands to one equal flag.
// Assumes the operands are already resolved by the forwarding logic.
module npc_compare
    import npc_pkg::*;
#(
    parameter int P_DATA_W = DATA_W
) (
    input  logic [P_DATA_W-1:0] opnd_a,
    input  logic [P_DATA_W-1:0] opnd_b,
    output logic                equal
);
    logic [P_DATA_W-1:0] diff_bits;

    // Per-bit difference, then an OR reduction.
    always_comb begin
        diff_bits = opnd_a ^ opnd_b;
        equal     = ~|diff_bits;
    end
endmodule

// File: rtl/npc_select.sv
// Selector: decides the next-address source by priority and drives the mux.
// Assumes jump outranks equal-branch, which outranks not-equal-branch.
module npc_select
    import npc_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic                is_beq,
    input  logic                is_bne,
    input  logic                is_jmp,
    input  logic                equal,
    input  logic [P_ADDR_W-1:0] seq_addr,
    input  logic [P_ADDR_W-1:0] br_addr,
    input  logic [P_ADDR_W-1:0] jmp_addr,
    output logic [P_ADDR_W-1:0] next_pc,
    output logic                redirect
);
    npc_src_e src;

    // Priority decision among jump and the two branch kinds.
    always_comb begin
        if (is_jmp)                src = SRC_JUMP;
        else if (is_beq)           src = equal  ? SRC_BRANCH : SRC_SEQ;
        else if (is_bne)           src = !equal ? SRC_BRANCH : SRC_SEQ;
        else                       src = SRC_SEQ;
    end

    // Address mux and redirect strobe from the chosen source.
    always_comb begin
        unique case (src)
            SRC_JUMP:   next_pc = jmp_addr;
            SRC_BRANCH: next_pc = br_addr;
            default:    next_pc = seq_addr;
        endcase
        redirect = (src != SRC_SEQ);
    end
endmodule

// File: rtl/npc_decode_resolve.sv
// Top: decode-stage next-address resolver with early branch compare.
// Combinational; the fetch stage registers next_pc and uses redirect_flush
// to clear its fetch/decode register in the same cycle.
module npc_decode_resolve
    import npc_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_OFF_W  = OFF_W,
    parameter int P_JFLD_W = JFLD_W,
    parameter int P_DATA_W = DATA_W
) (
    input  logic [P_ADDR_W-1:0] pc_inc,
    input  logic [P_OFF_W-1:0]  br_off,
    input  logic [P_JFLD_W-1:0] jmp_field,
    input  logic                is_beq,
    input  logic                is_bne,
    input  logic                is_jmp,
    input  logic [P_DATA_W-1:0] opnd_a,
    input  logic [P_DATA_W-1:0] opnd_b,
    output logic [P_ADDR_W-1:0] next_pc,
    output logic                redirect_flush
);
    logic [P_ADDR_W-1:0] seq_addr;
    logic [P_ADDR_W-1:0] br_addr;
    logic [P_ADDR_W-1:0] jmp_addr;
    logic                equal;

    npc_target_gen #(
        .P_ADDR_W(P_ADDR_W), .P_OFF_W(P_OFF_W), .P_JFLD_W(P_JFLD_W)
    ) u_tgt (
        .pc_inc(pc_inc), .br_off(br_off), .jmp_field(jmp_field),
        .seq_addr(seq_addr), .br_addr(br_addr), .jmp_addr(jmp_addr)
    );

    npc_compare #(.P_DATA_W(P_DATA_W)) u_cmp (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .equal(equal)
    );

    npc_select #(.P_ADDR_W(P_ADDR_W)) u_sel (
        .is_beq(is_beq), .is_bne(is_bne), .is_jmp(is_jmp), .equal(equal),
        .seq_addr(seq_addr), .br_addr(br_addr), .jmp_addr(jmp_addr),
        .next_pc(next_pc), .redirect(redirect_flush)
    );
endmodule

// File: rtl/npc_decode_resolve_chk.sv
// Checker: port-level properties of the resolver, bound to the top module.
// Immediate assertions, since the block has no clock of its own.
module npc_decode_resolve_chk #(
    parameter int P_ADDR_W = 32,
    parameter int P_DATA_W = 32
) (
    input logic [P_ADDR_W-1:0] pc_inc,
    input logic                is_beq,
    input logic                is_bne,
    input logic                is_jmp,
    input logic [P_DATA_W-1:0] opnd_a,
    input logic [P_DATA_W-1:0] opnd_b,
    input logic [P_ADDR_W-1:0] next_pc,
    input logic                redirect_flush
);
    logic [P_ADDR_W-1:0] fall_thru;

    // Fall-through address derived at the ports.
    always_comb fall_thru = {pc_inc[P_ADDR_W-1:2], 2'b00};

    // Port-level property checks.
    always_comb begin
        if (!is_beq && !is_bne && !is_jmp)
            p_idle_seq_r1: assert (next_pc == fall_thru && !redirect_flush)
                else $error("idle path redirected");
        if (is_beq && !is_jmp)
            p_beq_dec_r3: assert (redirect_flush == (opnd_a == opnd_b))
                else $error("beq decision wrong");
        if (is_bne && !is_beq && !is_jmp)
            p_bne_dec_r4: assert (redirect_flush == (opnd_a != opnd_b))
                else $error("bne decision wrong");
        if (is_jmp)
            p_jmp_region_r5: assert (redirect_flush &&
                                     next_pc[P_ADDR_W-1 -: 4] == pc_inc[P_ADDR_W-1 -: 4])
                else $error("jump region or flush wrong");
        if (!redirect_flush)
            p_noflush_seq_r6: assert (next_pc == fall_thru)
                else $error("address moved without flush");
        p_aligned_r7: assert (next_pc[1:0] == 2'b00)
            else $error("misaligned next address");
    end
endmodule

bind npc_decode_resolve npc_decode_resolve_chk #(
    .P_ADDR_W(P_ADDR_W), .P_DATA_W(P_DATA_W)
) u_chk (
    .pc_inc(pc_inc), .is_beq(is_beq), .is_bne(is_bne), .is_jmp(is_jmp),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .next_pc(next_pc),
    .redirect_flush(redirect_flush)
);

// File: tb/npc_decode_resolve_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module npc_decode_resolve_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_inc = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic        is_beq = 1'b0, is_bne = 1'b0, is_jmp = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [31:0] next_pc;
    logic        redirect_flush;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    npc_decode_resolve u_npc_decode_resolve (
        .pc_inc(pc_inc), .br_off(br_off), .jmp_field(jmp_field),
        .is_beq(is_beq), .is_bne(is_bne), .is_jmp(is_jmp),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .next_pc(next_pc), .redirect_flush(redirect_flush)
    );

    function automatic logic [31:0] br_tgt(input logic [31:0] p, input logic [15:0] o);
        return p + ({{16{o[15]}}, o} << 2);
    endfunction

    function automatic logic [31:0] j_tgt(input logic [31:0] p, input logic [25:0] f);
        return {p[31:28], f, 2'b00};
    endfunction

    task automatic apply(input logic [31:0] p, input logic [15:0] o, input logic [25:0] f,
                         input logic b, input logic n, input logic j,
                         input logic [31:0] a, input logic [31:0] c);
        @(negedge clk);
        pc_inc = p; br_off = o; jmp_field = f;
        is_beq = b; is_bne = n; is_jmp = j; opnd_a = a; opnd_b = c;
        #2;
    endtask

    task automatic expect_out(input string req, input logic [31:0] exp_pc, input logic exp_fl);
        checks++;
        if (next_pc !== exp_pc || redirect_flush !== exp_fl) begin
            failures++;
            $display("FAIL %s: next_pc=%h flush=%b expected next_pc=%h flush=%b",
                     req, next_pc, redirect_flush, exp_pc, exp_fl);
        end
    endtask

    task automatic t_reset_idle();
        apply(32'h0, 16'h0, 26'h0, 0, 0, 0, 32'h0, 32'h0);
        expect_out("R1 reset idle", 32'h0, 1'b0);
    endtask

    task automatic t_idle_operands();
        apply(32'h0040_1004, 16'h0010, 26'h123, 0, 0, 0, 32'h5, 32'h5);
        expect_out("R1 idle equal operands", 32'h0040_1004, 1'b0);
        apply(32'h0040_1007, 16'h0010, 26'h123, 0, 0, 0, 32'h5, 32'h6);
        expect_out("R7 idle low bits cleared", 32'h0040_1004, 1'b0);
    endtask

    task automatic t_beq();
        apply(32'h0000_2000, 16'h0020, 26'h0, 1, 0, 0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        expect_out("R3 R2 beq taken fwd", br_tgt(32'h0000_2000, 16'h0020), 1'b1);
        apply(32'h0000_2000, 16'hFFF0, 26'h0, 1, 0, 0, 32'h7, 32'h7);
        expect_out("R2 beq taken back", br_tgt(32'h0000_2000, 16'hFFF0), 1'b1);
        apply(32'h0000_2000, 16'h0020, 26'h0, 1, 0, 0, 32'h8000_0000, 32'h0);
        expect_out("R3 beq not taken msb", 32'h0000_2000, 1'b0);
    endtask

    task automatic t_bne();
        apply(32'h1000_0100, 16'h7FFF, 26'h0, 0, 1, 0, 32'h1, 32'h0);
        expect_out("R4 bne taken max off", br_tgt(32'h1000_0100, 16'h7FFF), 1'b1);
        apply(32'h1000_0100, 16'h8000, 26'h0, 0, 1, 0, 32'h3, 32'h2);
        expect_out("R4 bne taken min off", br_tgt(32'h1000_0100, 16'h8000), 1'b1);
        apply(32'h1000_0100, 16'h0004, 26'h0, 0, 1, 0, 32'hA5A5, 32'hA5A5);
        expect_out("R4 bne not taken", 32'h1000_0100, 1'b0);
    endtask

    task automatic t_wrap();
        apply(32'h0, 16'hFFFF, 26'h0, 1, 0, 0, 32'h0, 32'h0);
        expect_out("R7 wrap below zero", 32'hFFFF_FFFC, 1'b1);
        apply(32'hFFFF_FFFC, 16'h0001, 26'h0, 0, 1, 0, 32'h1, 32'h2);
        expect_out("R7 wrap above top", 32'h0, 1'b1);
        apply(32'h4, 16'hFFFF, 26'h0, 1, 0, 0, 32'h9, 32'h9);
        expect_out("R2 target zero", 32'h0, 1'b1);
    endtask

    task automatic t_jump();
        apply(32'hA000_0040, 16'h0, 26'h3FF_FFFF, 0, 0, 1, 32'h1, 32'h2);
        expect_out("R5 jump all ones field", j_tgt(32'hA000_0040, 26'h3FF_FFFF), 1'b1);
        apply(32'h5FFF_FFF0, 16'h0, 26'h000_0001, 0, 0, 1, 32'h1, 32'h1);
        expect_out("R5 R6 jump region", 32'h5000_0004, 1'b1);
    endtask

    task automatic t_priority();
        apply(32'h3000_1000, 16'h0040, 26'h0AB_CDEF, 1, 0, 1, 32'h4, 32'h4);
        expect_out("R8 jump over beq", j_tgt(32'h3000_1000, 26'h0AB_CDEF), 1'b1);
        apply(32'h3000_1000, 16'h0040, 26'h0AB_CDEF, 0, 1, 1, 32'h4, 32'h5);
        expect_out("R8 jump over bne", j_tgt(32'h3000_1000, 26'h0AB_CDEF), 1'b1);
        apply(32'h3000_1000, 16'h0040, 26'h0, 1, 1, 0, 32'h4, 32'h5);
        expect_out("R8 beq over bne", 32'h3000_1000, 1'b0);
        apply(32'h3000_1000, 16'h0040, 26'h0, 1, 1, 0, 32'h4, 32'h4);
        expect_out("R8 R6 beq over bne taken", br_tgt(32'h3000_1000, 16'h0040), 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_idle_operands();
        t_beq();
        t_bne();
        t_wrap();
        t_jump();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule